// File: doc/BRIEF.md
# Power-Up Reset Sequencer with Start-Up Delay

This block combines the reset causes of a small microcontroller core into one internal reset. It takes four causes: a power-on event, a brown-out event, a watchdog expiry and an active-low external reset pin. A set/reset state bit holds the core in reset. After power-on, a delay counter clocked by the free-running RC clock keeps the core in reset for a fixed start-up period before the state bit is released. The counter waits until the external pin has been seen high.

The power-on and brown-out events arrive as digital levels from analog detectors outside the block. The watchdog expiry comes from a watchdog outside the block. Brown-out and watchdog expiry are synchronous to the RC clock. Power-on is an asynchronous level. The external pin is asynchronous and passes through a two-flop synchronizer.

While the internal reset is active, the block raises a program-counter load strobe. It also drives the highest program-memory address as the restart vector, so the core always starts at the top of its program memory. Only the power-on path waits for the start-up delay. Brown-out and watchdog resets release one clock after their cause goes away. A pin reset after a completed start-up releases as soon as the synchronized pin is high again.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_evt` is high, `core_rst` and `pc_load` are 1 and `delay_done` is 0, with no clock edge needed.
- R2: `pc_load` equals `core_rst`. While `core_rst` is 1, `pc_vector` is MEM_WORDS-1 (0x7FF for the default 2048 words). While `core_rst` is 0, `pc_vector` is 0.
- R3: The delay counter does not advance until the pin has passed the two-flop synchronizer as high. After `por_evt` falls with the pin held low, `core_rst` stays 1.
- R4: Counting from the first rising clock edge at which `ext_rst_n` is high after power-on, `delay_done` goes to 1 after edge TERM_CNT+3. `core_rst` goes to 0 after the next edge.
- R5: A low level on `ext_rst_n` asserts `core_rst` after the third rising edge that sees it low. Once the delay has completed, `core_rst` releases after the third rising edge that sees the pin high again.
- R6: A brown-out level asserts `core_rst` in the same cycle. `core_rst` releases after the first rising edge at which the brown-out level is low, with no start-up delay. `delay_done` is unchanged.
- R7: A watchdog expiry asserts `core_rst` in the same cycle. `core_rst` releases after the first rising edge at which the expiry level is low, with no start-up delay.
- R8: Once `delay_done` is 1, it stays 1 through pin, brown-out and watchdog resets until the next power-on event.
- R9: If the synchronized pin falls low before the delay completes, the counter restarts from zero. The full delay is measured again from the pin's next high level.
- R10: The terminal count is the parameter TERM_CNT (default 1023). The counter never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Free-running RC oscillator clock |
| por_evt | input | 1 | Power-on event, active high, asynchronous |
| bor_evt | input | 1 | Brown-out event, active high |
| wdt_expire | input | 1 | Watchdog expiry, active high |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| core_rst | output | 1 | Internal reset to the core, active high |
| delay_done | output | 1 | Start-up delay completed flag |
| pc_load | output | 1 | Program-counter load strobe |
| pc_vector | output | PC_W | Reset vector, the top program-memory address |

## Verification
The bench counts the exact number of edges from the pin rising to `delay_done` and then to release. A synchronizer that is one stage short would show up as a count one lower. A counter compared against the wrong terminal value would show up as a count one off. A pin glitch during counting must restart the whole delay; a design that only paused the counter would release early. The bench also checks three release paths: brown-out, watchdog and a pin reset after start-up. Each must release within one to three edges. A design that re-armed the start-up delay on these paths, or cleared the timeout flag outside power-on, would stay in reset far too long.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int MEM_WORDS = 2048,
  parameter int TERM_CNT  = 1023,
  parameter int PC_W      = $clog2(MEM_WORDS)
) (
  input  logic            clk_rc,
  input  logic            por_evt,
  input  logic            bor_evt,
  input  logic            wdt_expire,
  input  logic            ext_rst_n,
  output logic            core_rst,
  output logic            delay_done,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_vector
);

  localparam int CNT_W = $clog2(TERM_CNT + 1);
  localparam logic [CNT_W-1:0] TERM     = CNT_W'(TERM_CNT);
  localparam logic [PC_W-1:0]  TOP_ADDR = PC_W'(MEM_WORDS - 1);

  logic             pin_meta, pin_ok;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             rst_q;
  logic             set_req;

  always_ff @(posedge clk_rc or posedge por_evt) begin
    if (por_evt) begin
      pin_meta <= 1'b0;
      pin_ok   <= 1'b0;
    end else begin
      pin_meta <= ext_rst_n;
      pin_ok   <= pin_meta;
    end
  end

  always_ff @(posedge clk_rc or posedge por_evt) begin
    if (por_evt) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!pin_ok) begin
      cnt_q  <= '0;
    end else if (!done_q) begin
      if (cnt_q == TERM) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign set_req = bor_evt | wdt_expire | ~pin_ok;

  always_ff @(posedge clk_rc or posedge por_evt) begin
    if (por_evt)      rst_q <= 1'b1;
    else if (set_req) rst_q <= 1'b1;
    else if (done_q)  rst_q <= 1'b0;
  end

  assign core_rst   = por_evt | rst_q | bor_evt | wdt_expire;
  assign pc_load    = core_rst;
  assign pc_vector  = core_rst ? TOP_ADDR : '0;
  assign delay_done = done_q;

  p_bor_sets_r6: assert property (@(posedge clk_rc) disable iff (por_evt)
    bor_evt |=> rst_q);
  p_wdt_sets_r7: assert property (@(posedge clk_rc) disable iff (por_evt)
    wdt_expire |=> rst_q);
  p_pin_sets_r5: assert property (@(posedge clk_rc) disable iff (por_evt)
    !pin_ok |=> rst_q);
  p_done_sticky_r8: assert property (@(posedge clk_rc) disable iff (por_evt)
    done_q |=> done_q);
  p_done_needs_pin_r3: assert property (@(posedge clk_rc) disable iff (por_evt)
    $rose(done_q) |-> $past(pin_ok));
  p_release_after_delay_r4: assert property (@(posedge clk_rc) disable iff (por_evt)
    $fell(rst_q) |-> done_q);
  p_cnt_bound_r10: assert property (@(posedge clk_rc) disable iff (por_evt)
    cnt_q <= TERM);
  p_vector_top_r2: assert property (@(posedge clk_rc) disable iff (por_evt)
    pc_load |-> pc_vector == TOP_ADDR);

endmodule

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
  localparam int TERM = 20;
  localparam int PCW  = 11;

  logic clk = 1'b0;
  logic por = 1'b1, bor = 1'b0, wdt = 1'b0, pin = 1'b0;
  logic core_rst, delay_done, pc_load;
  logic [PCW-1:0] pc_vector;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rst_sequencer #(.MEM_WORDS(2048), .TERM_CNT(TERM)) u_rst_sequencer (
    .clk_rc(clk), .por_evt(por), .bor_evt(bor), .wdt_expire(wdt),
    .ext_rst_n(pin), .core_rst(core_rst), .delay_done(delay_done),
    .pc_load(pc_load), .pc_vector(pc_vector));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_to_done(input string req);
    int n = 0;
    while (!delay_done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == TERM + 3, req, n, TERM + 3);
    @(negedge clk);
    chk(core_rst == 1'b0, req, core_rst, 0);
  endtask

  task automatic t_power_on();
    @(negedge clk); @(negedge clk);
    chk(core_rst && pc_load && !delay_done, "R1", {core_rst, pc_load, delay_done}, 3'b110);
    chk(pc_vector == 11'h7FF, "R2", pc_vector, 11'h7FF);
  endtask

  task automatic t_pin_held_low();
    por = 1'b0;
    repeat (40) @(negedge clk);
    chk(core_rst && !delay_done, "R3", {core_rst, delay_done}, 2'b10);
  endtask

  task automatic t_startup_delay();
    pin = 1'b1;
    count_to_done("R4");
    chk(pc_load == 1'b0 && pc_vector == '0, "R2", pc_vector, 0);
  endtask

  task automatic t_brownout();
    bor = 1'b1; #1;
    chk(core_rst == 1'b1, "R6", core_rst, 1);
    repeat (3) @(negedge clk);
    bor = 1'b0; #1;
    chk(core_rst == 1'b1, "R6", core_rst, 1);
    @(negedge clk);
    chk(core_rst == 1'b0 && delay_done, "R6", {core_rst, delay_done}, 2'b01);
  endtask

  task automatic t_watchdog();
    wdt = 1'b1; #1;
    chk(core_rst == 1'b1, "R7", core_rst, 1);
    @(negedge clk);
    wdt = 1'b0; #1;
    chk(core_rst == 1'b1, "R7", core_rst, 1);
    @(negedge clk);
    chk(core_rst == 1'b0, "R7", core_rst, 0);
  endtask

  task automatic t_pin_reset_after_start();
    pin = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(core_rst == 1'b0, "R5", core_rst, 0);
    @(negedge clk);
    chk(core_rst == 1'b1, "R5", core_rst, 1);
    repeat (5) @(negedge clk);
    pin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(core_rst == 1'b1, "R5", core_rst, 1);
    @(negedge clk);
    chk(core_rst == 1'b0, "R5", core_rst, 0);
    chk(delay_done == 1'b1, "R8", delay_done, 1);
  endtask

  task automatic t_repower_with_glitch();
    por = 1'b1; #1;
    chk(delay_done == 1'b0 && core_rst, "R1", {core_rst, delay_done}, 2'b10);
    @(negedge clk);
    por = 1'b0;
    repeat (10) @(negedge clk);
    pin = 1'b0;
    repeat (4) @(negedge clk);
    pin = 1'b1;
    count_to_done("R9");
  endtask

  task automatic t_repower_pin_high();
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    count_to_done("R10");
  endtask

  initial begin
    t_power_on();
    t_pin_held_low();
    t_startup_delay();
    t_brownout();
    t_watchdog();
    t_pin_reset_after_start();
    t_repower_with_glitch();
    t_repower_pin_high();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule